// File: doc/BRIEF.md
# Reset-Aware Clock-Stop Sequencer for an Isolated Logic Group

This controller drives the clock-stop lines, the flush-clock enable and the scan enable for a group of downstream logic blocks. The group does not follow the chip-wide reset recipe. It is never flushed by a reset. It keeps running while a debug reset is active. It leaves the first power-on phase on its own early release request, which arrives before the chip-wide flush-stop release. The controller reads the reset kind currently in progress and selects, on every cycle, which request sources reach its outputs.

During the first power-on phase, a four-step sequencer releases the group. The stops start asserted. After the early release request, the controller first releases its own flush-reset condition. It then drops the group clock stops, and then drops the scan enable. During warm resets, the stops track the normal chip stop sequence, and flush stays off. With no reset in progress, the group obeys test-port stop and flush requests like any other block and otherwise rests idle. Every output is registered, so an output reflects the inputs sampled at the previous clock edge.

Top module: `grp_clkstop_ctrl`

## Requirements
- R1: While the reset kind is first power-on (code 1) and the early release has not yet been taken, every group stop output is high, scan enable is high and the self-release flag is low.
- R2: An early release request sampled in first power-on sets the self-release flag one edge later while stops and scan stay high. On the next edge all stops go low while scan stays high. On the edge after that scan goes low.
- R3: The flush-clock enable is never high in the cycle after a first power-on cycle, even with a test-port flush request present.
- R4: During either warm reset (codes 3 and 4) the group stops equal the chip stop request sampled one cycle earlier, and the flush-clock enable stays low.
- R5: During debug reset (code 5) every group stop output is low.
- R6: During second power-on (code 4 is warm; code 2 is second power-on) every group stop output is low whatever the chip stop request is.
- R7: With no reset in progress (code 0), the group stops follow the test-port stop request and the flush-clock enable follows the test-port flush request, each one cycle later.
- R8: Under synchronous reset, and with no reset kind active and no test-port request (codes 0, 6 and 7 count as no reset), all outputs are low.
- R9: Debug reset takes priority over a simultaneous non-zero chip stop request: the stops stay low.
- R10: An early release request presented while the reset kind is not first power-on is ignored: a later first power-on phase still starts with all stops high and the self-release flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_kind_i | input | KIND_W (3) | Reset kind in progress: 0 none, 1 first power-on, 2 second power-on, 3 warm A, 4 warm B, 5 debug |
| early_rel_i | input | 1 | Early flush-stop release request for the group |
| chip_stop_req_i | input | N_GRP (4) | Normal chip-wide clock-stop sequence request, one bit per block |
| jtag_stop_req_i | input | N_GRP (4) | Test-port clock-stop request, one bit per block |
| jtag_flush_req_i | input | 1 | Test-port flush clock request |
| grp_stop_o | output | N_GRP (4) | Clock stop per block of the group |
| flush_clk_en_o | output | 1 | Flush clock pulse enable to the group |
| scan_en_o | output | 1 | Scan enable to the group |
| self_rel_o | output | 1 | Controller has released its own flush-reset condition |

## Verification
The assertions check on every cycle that each reset kind maps to its output policy. Flush is never enabled after a first power-on cycle. Stops are low under debug and second power-on. Stops track the chip request during warm resets. The release sequencer only steps forward in its fixed order, and scan never drops in first power-on before the self-release flag is set. Only the bench scenarios can show the exact edge of each release step, that an early release outside first power-on leaves the sequencer armed, the debug-over-stop priority with real stop patterns, and the test-port path in the idle state.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int ENC_KIND_W    = 3;
    localparam int ONEHOT_KIND_W = 5;

    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_POR1   = 3'd1,
        RK_POR2   = 3'd2,
        RK_WARM_A = 3'd3,
        RK_WARM_B = 3'd4,
        RK_DEBUG  = 3'd5
    } rst_kind_e;

    typedef enum logic [1:0] {
        SQ_HOLD     = 2'd0,
        SQ_SELF_REL = 2'd1,
        SQ_STOP_REL = 2'd2,
        SQ_RUN      = 2'd3
    } por_seq_e;

    typedef struct packed {
        logic por1;
        logic por2;
        logic warm;
        logic debug;
    } kind_flags_t;

    function automatic int kind_width(bit onehot);
        return onehot ? ONEHOT_KIND_W : ENC_KIND_W;
    endfunction

    function automatic kind_flags_t flags_of_code(logic [2:0] code);
        kind_flags_t f;
        f = '0;
        case (code)
            RK_POR1:   f.por1  = 1'b1;
            RK_POR2:   f.por2  = 1'b1;
            RK_WARM_A: f.warm  = 1'b1;
            RK_WARM_B: f.warm  = 1'b1;
            RK_DEBUG:  f.debug = 1'b1;
            default:   f       = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/csc_kind_decode.sv
module csc_kind_decode
    import csc_pkg::*;
#(
    parameter bit KIND_ONEHOT = 1'b0,
    parameter int KIND_W      = kind_width(KIND_ONEHOT)
) (
    input  logic [KIND_W-1:0] kind_i,
    output kind_flags_t       flags_o
);

    generate
        if (KIND_ONEHOT) begin : g_onehot
            // bit order: 0 por1, 1 por2, 2 warm A, 3 warm B, 4 debug
            always_comb begin
                flags_o = '0;
                if (kind_i[4])                  flags_o.debug = 1'b1;
                else if (kind_i[0])             flags_o.por1  = 1'b1;
                else if (kind_i[1])             flags_o.por2  = 1'b1;
                else if (kind_i[2] | kind_i[3]) flags_o.warm  = 1'b1;
            end
        end else begin : g_encoded
            always_comb flags_o = flags_of_code(kind_i[2:0]);
        end
    endgenerate

endmodule

// File: rtl/csc_por_seq.sv
module csc_por_seq
    import csc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     por1_i,
    input  logic     release_i,
    output por_seq_e state_o
);

    por_seq_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_HOLD:     if (por1_i && release_i) state_d = SQ_SELF_REL;
            SQ_SELF_REL: state_d = SQ_STOP_REL;
            SQ_STOP_REL: state_d = SQ_RUN;
            default:     state_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_HOLD;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R2
    self_then_stop_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == SQ_SELF_REL |=> state_q == SQ_STOP_REL);

    // R2
    stop_then_run_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == SQ_STOP_REL |=> state_q == SQ_RUN);

    // R10
    hold_without_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_HOLD && !(por1_i && release_i)) |=> state_q == SQ_HOLD);

endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage
    import csc_pkg::*;
#(
    parameter int N_GRP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  kind_flags_t      flags_i,
    input  por_seq_e         seq_i,
    input  logic [N_GRP-1:0] chip_stop_i,
    input  logic [N_GRP-1:0] jtag_stop_i,
    input  logic             jtag_flush_i,
    output logic [N_GRP-1:0] grp_stop_o,
    output logic             flush_o,
    output logic             scan_o,
    output logic             self_rel_o
);

    localparam logic [N_GRP-1:0] ALL_STOP = {N_GRP{1'b1}};

    logic [N_GRP-1:0] stop_d;
    logic             flush_d, scan_d, rel_d;

    always_comb begin
        stop_d  = '0;
        flush_d = 1'b0;
        scan_d  = 1'b0;
        rel_d   = (seq_i != SQ_HOLD);
        if (flags_i.debug) begin
            stop_d = '0;
        end else if (flags_i.por1) begin
            stop_d = (seq_i == SQ_HOLD || seq_i == SQ_SELF_REL) ? ALL_STOP : '0;
            scan_d = (seq_i != SQ_RUN);
        end else if (flags_i.por2) begin
            stop_d = '0;
        end else if (flags_i.warm) begin
            stop_d = chip_stop_i;
        end else begin
            stop_d  = jtag_stop_i;
            flush_d = jtag_flush_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_stop_o <= '0;
            flush_o    <= 1'b0;
            scan_o     <= 1'b0;
            self_rel_o <= 1'b0;
        end else begin
            grp_stop_o <= stop_d;
            flush_o    <= flush_d;
            scan_o     <= scan_d;
            self_rel_o <= rel_d;
        end
    end

    // R1
    por1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_i.por1 && !flags_i.debug && seq_i == SQ_HOLD) |=>
            (grp_stop_o == ALL_STOP && scan_o && !self_rel_o));

    // R3
    por1_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flags_i.por1 |=> !flush_o);

    // R4
    warm_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_i.warm && !flags_i.debug && !flags_i.por1 && !flags_i.por2) |=>
            (grp_stop_o == $past(chip_stop_i) && !flush_o));

    // R5
    debug_run_chk: assert property (@(posedge clk) disable iff (rst)
        flags_i.debug |=> grp_stop_o == '0);

    // R6
    por2_run_chk: assert property (@(posedge clk) disable iff (rst)
        flags_i.por2 |=> grp_stop_o == '0);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_i == '0 && jtag_stop_i == '0 && !jtag_flush_i) |=>
            (grp_stop_o == '0 && !flush_o && !scan_o));

endmodule

// File: rtl/grp_clkstop_ctrl.sv
module grp_clkstop_ctrl
    import csc_pkg::*;
#(
    parameter int N_GRP       = 4,
    parameter bit KIND_ONEHOT = 1'b0,
    parameter int KIND_W      = kind_width(KIND_ONEHOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] rst_kind_i,
    input  logic              early_rel_i,
    input  logic [N_GRP-1:0]  chip_stop_req_i,
    input  logic [N_GRP-1:0]  jtag_stop_req_i,
    input  logic              jtag_flush_req_i,
    output logic [N_GRP-1:0]  grp_stop_o,
    output logic              flush_clk_en_o,
    output logic              scan_en_o,
    output logic              self_rel_o
);

    kind_flags_t flags;
    por_seq_e    seq;

    csc_kind_decode #(
        .KIND_ONEHOT (KIND_ONEHOT),
        .KIND_W      (KIND_W)
    ) kind_dec_i (
        .kind_i  (rst_kind_i),
        .flags_o (flags)
    );

    csc_por_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .por1_i    (flags.por1),
        .release_i (early_rel_i),
        .state_o   (seq)
    );

    csc_out_stage #(
        .N_GRP (N_GRP)
    ) out_i (
        .clk          (clk),
        .rst          (rst),
        .flags_i      (flags),
        .seq_i        (seq),
        .chip_stop_i  (chip_stop_req_i),
        .jtag_stop_i  (jtag_stop_req_i),
        .jtag_flush_i (jtag_flush_req_i),
        .grp_stop_o   (grp_stop_o),
        .flush_o      (flush_clk_en_o),
        .scan_o       (scan_en_o),
        .self_rel_o   (self_rel_o)
    );

    // R2
    scan_drop_after_rel_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(scan_en_o) && $past(flags.por1)) |-> self_rel_o);

endmodule

// File: tb/grp_clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module grp_clkstop_ctrl_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   kind;
    logic         early_rel;
    logic [N-1:0] chip_stop, jtag_stop;
    logic         jtag_flush;
    logic [N-1:0] grp_stop;
    logic         flush_en, scan_en, self_rel;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    grp_clkstop_ctrl #(.N_GRP(N)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .rst_kind_i       (kind),
        .early_rel_i      (early_rel),
        .chip_stop_req_i  (chip_stop),
        .jtag_stop_req_i  (jtag_stop),
        .jtag_flush_req_i (jtag_flush),
        .grp_stop_o       (grp_stop),
        .flush_clk_en_o   (flush_en),
        .scan_en_o        (scan_en),
        .self_rel_o       (self_rel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; kind = 3'd0; early_rel = 1'b0;
        chip_stop = '0; jtag_stop = '0; jtag_flush = 1'b0;
        step(3);
    endtask

    task automatic t_reset_idle();
        apply_reset();
        chk("R8 reset stops", grp_stop, 0);
        chk("R8 reset scan/flush/rel", {scan_en, flush_en, self_rel}, 0);
        rst = 1'b0;
        step(2);
        chk("R8 idle stops", grp_stop, 0);
        chk("R8 idle scan/flush", {scan_en, flush_en}, 0);
        kind = 3'd6;
        step(2);
        chk("R8 code 6 idle", {grp_stop, scan_en, flush_en}, 0);
    endtask

    task automatic t_ignore_release();
        apply_reset();
        rst = 1'b0;
        kind = 3'd3; early_rel = 1'b1;
        step(1);
        early_rel = 1'b0;
        step(2);
        kind = 3'd1;
        step(3);
        chk("R10 stops still held", grp_stop, 4'hF);
        chk("R10 self release low", self_rel, 0);
    endtask

    task automatic t_por1_sequence();
        apply_reset();
        rst = 1'b0;
        kind = 3'd1; jtag_flush = 1'b1; jtag_stop = 4'h0; chip_stop = 4'h5;
        step(3);
        chk("R1 hold stops", grp_stop, 4'hF);
        chk("R1 hold scan/rel", {scan_en, self_rel}, 2'b10);
        chk("R3 no flush in hold", flush_en, 0);
        early_rel = 1'b1;
        step(1);
        early_rel = 1'b0;
        chk("R2 edge1 unchanged", {grp_stop, scan_en, self_rel}, {4'hF, 2'b10});
        step(1);
        chk("R2 edge2 self release", {grp_stop, scan_en, self_rel}, {4'hF, 2'b11});
        step(1);
        chk("R2 edge3 stops drop", {grp_stop, scan_en, self_rel}, {4'h0, 2'b11});
        step(1);
        chk("R2 edge4 scan drop", {grp_stop, scan_en, self_rel}, {4'h0, 2'b01});
        chk("R3 no flush after release", flush_en, 0);
        jtag_flush = 1'b0;
    endtask

    task automatic t_por2();
        kind = 3'd2; chip_stop = 4'hF;
        step(2);
        chk("R6 por2 stops low", grp_stop, 0);
    endtask

    task automatic t_warm();
        jtag_flush = 1'b1;
        kind = 3'd3; chip_stop = 4'hA;
        step(1);
        chk("R4 warm A follows", grp_stop, 4'hA);
        chk("R4 warm A no flush", flush_en, 0);
        chip_stop = 4'h3;
        step(1);
        chk("R4 warm A next pattern", grp_stop, 4'h3);
        kind = 3'd4; chip_stop = 4'hC;
        step(1);
        chk("R4 warm B follows", grp_stop, 4'hC);
        chk("R4 warm B no flush", flush_en, 0);
        jtag_flush = 1'b0;
    endtask

    task automatic t_debug();
        kind = 3'd5; chip_stop = 4'hF; jtag_stop = 4'hF;
        step(1);
        chk("R5 debug stops low", grp_stop, 0);
        chip_stop = 4'h6;
        step(2);
        chk("R9 debug beats chip stop", grp_stop, 0);
        jtag_stop = 4'h0;
    endtask

    task automatic t_jtag();
        kind = 3'd0; chip_stop = 4'hF; jtag_stop = 4'h9; jtag_flush = 1'b1;
        step(1);
        chk("R7 jtag stops", grp_stop, 4'h9);
        chk("R7 jtag flush", flush_en, 1);
        jtag_stop = 4'h4; jtag_flush = 1'b0;
        step(1);
        chk("R7 jtag stops change", grp_stop, 4'h4);
        chk("R7 jtag flush off", flush_en, 0);
        jtag_stop = 4'h0;
        step(1);
        chk("R8 back to idle", {grp_stop, scan_en, flush_en}, 0);
    endtask

    initial begin
        rst = 1'b1; kind = 3'd0; early_rel = 1'b0;
        chip_stop = '0; jtag_stop = '0; jtag_flush = 1'b0;
        t_reset_idle();
        t_ignore_release();
        t_por1_sequence();
        t_por2();
        t_warm();
        t_debug();
        t_jtag();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule